// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Conditioner

This block derives the timing signals a 16-bit processor needs from one free-running oscillator. It divides the oscillator by three to make the processor clock, which is high for one third of each period. It divides that clock by two to make a slower, symmetric clock for peripheral devices. Everything inside runs on the oscillator. The two clock outputs come straight from flip-flops, so they do not glitch.

A slow, bouncing active-low reset request is sampled only just before a rising edge of the processor clock. The reset output therefore rises on a clock edge. A stretch counter keeps it high for at least four processor-clock periods, however brief the request was. An external ready request is passed through one synchronizer stage or through two. A select input picks the depth at run time. The resulting READY output only ever changes on a falling edge of the processor clock.

A clock-sync input holds the dividers at their starting phase while it is high. The divide sequence restarts in a known phase once it falls, so several conditioners fed from one frequency source stay aligned.

Top module: `cpu_timing_cond`

## Requirements
- R1: While clkSync is high, clkOut is held high, pclkOut low, resetOut high and readyOut low. The divide phase is held at its start.
- R2: After clkSync falls, clkOut is low for the first two oscillator cycles and high on the third. It then repeats a three-cycle period in which it is high for exactly one cycle.
- R3: pclkOut toggles on every rising edge of clkOut and at no other time. Its period is therefore six oscillator cycles at 50 percent duty. The first toggle after clkSync falls goes high.
- R4: If rstReqN is low in the oscillator cycle just before a clkOut rising edge, resetOut is high from that edge onward.
- R5: resetOut falls only on the fourth clkOut rising edge after the last edge at which rstReqN was sampled low. Every RESET pulse therefore lasts at least four clkOut periods, even when the request lasted a single oscillator cycle.
- R6: With oneStageSel = 1, readyOut takes, at each clkOut falling edge, the value rdyReq had at the preceding clkOut rising edge. That is one synchronizer stage.
- R7: With oneStageSel = 0, readyOut takes, at each clkOut falling edge, the value rdyReq had one clkOut period earlier than in R6. That is two synchronizer stages.
- R8: readyOut changes only on a falling edge of clkOut.
- R9: A low pulse on rstReqN that does not cover the sampling cycle before a clkOut rising edge is ignored. resetOut stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Oscillator input; clocks every flip-flop in the block |
| clkSync | input | 1 | High holds the dividers at their starting phase and initialises the block |
| rstReqN | input | 1 | Active-low reset request, slow and unsynchronized |
| rdyReq | input | 1 | Ready request from memory or I/O, asynchronous |
| oneStageSel | input | 1 | 1 selects one ready synchronizer stage, 0 selects two |
| clkOut | output | 1 | Processor clock, oscillator divided by 3, high for one third of the period |
| pclkOut | output | 1 | Peripheral clock, clkOut divided by 2, 50 percent duty |
| resetOut | output | 1 | Clock-synchronized, stretched processor reset |
| readyOut | output | 1 | Synchronized ready, updated on clkOut falling edges |

## Verification
A wrong divide phase shows within three oscillator cycles as a misplaced clkOut high. It shows within six as a peripheral clock that toggles off a processor-clock rising edge. A stretch counter that is loaded or decremented wrongly shows as resetOut falling one processor-clock period early or late, at the fourth rising edge after the request is released. A ready stage that is shifted or selected wrongly shows at the next clkOut falling edge as a READY value one period stale or one period fresh.

// File: rtl/cpu_timing_cond_pkg.sv
package cpu_timing_cond_pkg;

  // Phase strobes from the divider control to the datapath, all for the
  // oscillator cycle in which they are high.
  typedef struct packed {
    logic holdSync;  // clock-sync active: initialise
    logic clkRise;   // clkOut rises at the end of this cycle
    logic clkFall;   // clkOut falls at the end of this cycle
  } phaseStrobe_t;

endpackage

// File: rtl/cpu_timing_cond_ctrl.sv
module cpu_timing_cond_ctrl
  import cpu_timing_cond_pkg::*;
#(
  parameter int DIV_N = 3
) (
  input  logic         oscClk,
  input  logic         clkSync,
  output phaseStrobe_t strobe,
  output logic         clkOut,
  output logic         pclkOut
);

  localparam int CW = (DIV_N > 2) ? $clog2(DIV_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

  logic [CW-1:0] phaseCnt;
  logic [CW-1:0] phaseNext;
  logic          clkQ;
  logic          pclkQ;

  always_comb begin
    phaseNext = (phaseCnt == LAST) ? '0 : phaseCnt + CW'(1);
  end

  always_comb begin
    strobe.holdSync = clkSync;
    strobe.clkRise  = !clkSync && (phaseCnt == LAST);
    strobe.clkFall  = !clkSync && (phaseCnt == '0);
  end

  always_ff @(posedge oscClk) begin
    if (clkSync) begin
      phaseCnt <= '0;
      clkQ     <= 1'b1;
      pclkQ    <= 1'b0;
    end else begin
      phaseCnt <= phaseNext;
      clkQ     <= (phaseNext == '0);
      if (strobe.clkRise) begin
        pclkQ <= ~pclkQ;
      end
    end
  end

  assign clkOut  = clkQ;
  assign pclkOut = pclkQ;

endmodule

// File: rtl/cpu_timing_cond_path.sv
module cpu_timing_cond_path
  import cpu_timing_cond_pkg::*;
#(
  parameter int RESET_MIN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         oscClk,
  input  phaseStrobe_t strobe,
  input  logic         rstReqN,
  input  logic         rdyReq,
  input  logic         oneStageSel,
  output logic         resetOut,
  output logic         readyOut
);

  localparam int HW = $clog2(RESET_MIN + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(RESET_MIN);

  logic [HW-1:0]          holdCnt;
  logic                   resetQ;
  logic [SYNC_STAGES-1:0] stageQ;
  logic                   readyQ;

  // Reset capture and stretch: sampled only ahead of a clkOut rising edge.
  always_ff @(posedge oscClk) begin
    if (strobe.holdSync) begin
      holdCnt <= HOLD_LOAD;
      resetQ  <= 1'b1;
    end else if (strobe.clkRise) begin
      if (!rstReqN) begin
        holdCnt <= HOLD_LOAD;
        resetQ  <= 1'b1;
      end else if (holdCnt > HW'(1)) begin
        holdCnt <= holdCnt - HW'(1);
      end else begin
        holdCnt <= '0;
        resetQ  <= 1'b0;
      end
    end
  end

  // Ready synchronizer chain, shifted on clkOut rising edges.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge oscClk) begin
        if (strobe.holdSync) begin
          stageQ[0] <= 1'b0;
        end else if (strobe.clkRise) begin
          stageQ[0] <= rdyReq;
        end
      end
    end else begin : gNext
      always_ff @(posedge oscClk) begin
        if (strobe.holdSync) begin
          stageQ[g] <= 1'b0;
        end else if (strobe.clkRise) begin
          stageQ[g] <= stageQ[g-1];
        end
      end
    end
  end

  // Output stage: depth picked at run time, updated on clkOut falling edges.
  always_ff @(posedge oscClk) begin
    if (strobe.holdSync) begin
      readyQ <= 1'b0;
    end else if (strobe.clkFall) begin
      readyQ <= oneStageSel ? stageQ[0] : stageQ[SYNC_STAGES-1];
    end
  end

  assign resetOut = resetQ;
  assign readyOut = readyQ;

endmodule

// File: rtl/cpu_timing_cond.sv
module cpu_timing_cond
  import cpu_timing_cond_pkg::*;
#(
  parameter int DIV_N       = 3,
  parameter int RESET_MIN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic oscClk,
  input  logic clkSync,
  input  logic rstReqN,
  input  logic rdyReq,
  input  logic oneStageSel,
  output logic clkOut,
  output logic pclkOut,
  output logic resetOut,
  output logic readyOut
);

  phaseStrobe_t strobe;

  cpu_timing_cond_ctrl #(
    .DIV_N(DIV_N)
  ) u_ctrl (
    .oscClk (oscClk),
    .clkSync(clkSync),
    .strobe (strobe),
    .clkOut (clkOut),
    .pclkOut(pclkOut)
  );

  cpu_timing_cond_path #(
    .RESET_MIN  (RESET_MIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .oscClk     (oscClk),
    .strobe     (strobe),
    .rstReqN    (rstReqN),
    .rdyReq     (rdyReq),
    .oneStageSel(oneStageSel),
    .resetOut   (resetOut),
    .readyOut   (readyOut)
  );

endmodule

// File: rtl/cpu_timing_cond_chk.sv
module cpu_timing_cond_chk #(
  parameter int RESET_MIN = 4
) (
  input logic oscClk,
  input logic clkSync,
  input logic rstReqN,
  input logic rdyReq,
  input logic oneStageSel,
  input logic clkOut,
  input logic pclkOut,
  input logic resetOut,
  input logic readyOut
);

  localparam int HW = $clog2(RESET_MIN + 1);

  logic [2:0]    sinceSync;
  logic [HW-1:0] hiCount;
  logic          prevClk;

  always_ff @(posedge oscClk) begin
    if (clkSync) begin
      sinceSync <= '0;
      hiCount   <= HW'(RESET_MIN);
      prevClk   <= 1'b1;
    end else begin
      prevClk <= clkOut;
      if (sinceSync != 3'd7) sinceSync <= sinceSync + 3'd1;
      if (!resetOut) begin
        hiCount <= '0;
      end else if (clkOut && !prevClk && hiCount != HW'(RESET_MIN)) begin
        hiCount <= hiCount + HW'(1);
      end
    end
  end

  assert_sync_hold_R1: assert property (@(posedge oscClk)
    clkSync |=> (clkOut && !pclkOut && resetOut && !readyOut));

  assert_clk_high_once_R2: assert property (@(posedge oscClk) disable iff (clkSync)
    $rose(clkOut) |=> !clkOut);

  assert_clk_low_twice_R2: assert property (@(posedge oscClk) disable iff (clkSync)
    $fell(clkOut) |=> !clkOut);

  assert_pclk_on_rise_R3: assert property (@(posedge oscClk) disable iff (clkSync)
    !$stable(pclkOut) |-> $rose(clkOut));

  assert_reset_capture_R4: assert property (@(posedge oscClk) disable iff (clkSync)
    ($rose(clkOut) && !$past(rstReqN)) |-> resetOut);

  assert_reset_min_len_R5: assert property (@(posedge oscClk) disable iff (clkSync)
    $fell(resetOut) |-> (hiCount >= HW'(RESET_MIN)));

  assert_ready_one_stage_R6: assert property (@(posedge oscClk) disable iff (clkSync)
    (sinceSync >= 3'd4 && $fell(clkOut) && $past(oneStageSel))
      |-> (readyOut == $past(rdyReq, 2)));

  assert_ready_two_stage_R7: assert property (@(posedge oscClk) disable iff (clkSync)
    (sinceSync >= 3'd7 && $fell(clkOut) && !$past(oneStageSel))
      |-> (readyOut == $past(rdyReq, 5)));

  assert_ready_on_fall_R8: assert property (@(posedge oscClk) disable iff (clkSync)
    !$stable(readyOut) |-> $fell(clkOut));

  assert_reset_on_rise_R9: assert property (@(posedge oscClk) disable iff (clkSync)
    !$rose(clkOut) |-> $stable(resetOut));

endmodule

bind cpu_timing_cond cpu_timing_cond_chk #(.RESET_MIN(RESET_MIN)) u_chk (
  .oscClk     (oscClk),
  .clkSync    (clkSync),
  .rstReqN    (rstReqN),
  .rdyReq     (rdyReq),
  .oneStageSel(oneStageSel),
  .clkOut     (clkOut),
  .pclkOut    (pclkOut),
  .resetOut   (resetOut),
  .readyOut   (readyOut)
);

// File: tb/cpu_timing_cond_bench.sv
module cpu_timing_cond_bench;

  localparam int STRETCH = 4;

  logic oscClk = 1'b0;
  always #2 oscClk = ~oscClk;

  logic clkSync, rstReqN, rdyReq, oneStageSel;
  logic clkOut, pclkOut, resetOut, readyOut;

  cpu_timing_cond u_cpu_timing_cond (
    .oscClk     (oscClk),
    .clkSync    (clkSync),
    .rstReqN    (rstReqN),
    .rdyReq     (rdyReq),
    .oneStageSel(oneStageSel),
    .clkOut     (clkOut),
    .pclkOut    (pclkOut),
    .resetOut   (resetOut),
    .readyOut   (readyOut)
  );

  // Behavioural reference: oscillator cycle count within a CLK period,
  // a pending-reset budget in CLK periods, and a queue of ready samples.
  int    mPh;
  int    mHold;
  bit    mClk, mPclk, mReset, mRdy;
  bit    rdyHist[$];
  bit    isRise, isFall;

  int    nTests = 0;
  int    nFail  = 0;
  bit    checkEn = 0;
  bit    done = 0;
  string resetTag = "R4";
  string readyTag = "R6";
  logic [7:0] lfsr = 8'hA5;

  always @(posedge oscClk) begin
    if (clkSync) begin
      mPh = 0; mClk = 1; mPclk = 0; mReset = 1; mRdy = 0;
      mHold = STRETCH;
      rdyHist = {1'b0, 1'b0};
    end else begin
      isRise = (mPh == 2);
      isFall = (mPh == 0);
      if (isFall) mRdy = oneStageSel ? rdyHist[0] : rdyHist[1];
      if (isRise) begin
        if (!rstReqN) begin
          mHold = STRETCH; mReset = 1;
        end else if (mHold > 1) begin
          mHold = mHold - 1;
        end else begin
          mHold = 0; mReset = 0;
        end
        rdyHist.push_front(rdyReq);
        void'(rdyHist.pop_back());
        mPclk = !mPclk;
      end
      mPh = (mPh + 1) % 3;
      mClk = (mPh == 0);
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge oscClk) begin
    if (checkEn && !done) begin
      check(clkSync ? "R1" : "R2", "clkOut",   clkOut,   mClk);
      check(clkSync ? "R1" : "R3", "pclkOut",  pclkOut,  mPclk);
      check(clkSync ? "R1" : resetTag, "resetOut", resetOut, mReset);
      check(clkSync ? "R1" : readyTag, "readyOut", readyOut, mRdy);
    end
  end

  task automatic waitPhase(int ph);
    do @(negedge oscClk); while (mPh != ph);
  endtask

  task automatic driveReady(int n, bit toggleMode);
    for (int i = 0; i < n; i++) begin
      @(negedge oscClk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdyReq = lfsr[0];
      if (toggleMode) oneStageSel = lfsr[3];
    end
  endtask

  initial begin
    clkSync = 1; rstReqN = 0; rdyReq = 0; oneStageSel = 1;
    repeat (3) @(negedge oscClk);
    checkEn = 1;
    // R1: held state while clock-sync is high
    repeat (6) @(negedge oscClk);
    // R2, R3, R4: release sync with reset requested
    clkSync = 0; resetTag = "R4";
    repeat (20) @(negedge oscClk);
    // R5: release the request, RESET must stretch
    rstReqN = 1; resetTag = "R5";
    repeat (30) @(negedge oscClk);
    // R5: one-cycle request covering the sampling cycle
    waitPhase(2); rstReqN = 0;
    @(negedge oscClk); rstReqN = 1;
    repeat (30) @(negedge oscClk);
    // R9: one-cycle glitches outside the sampling cycle
    resetTag = "R9";
    waitPhase(0); rstReqN = 0;
    @(negedge oscClk); rstReqN = 1;
    repeat (10) @(negedge oscClk);
    waitPhase(1); rstReqN = 0;
    @(negedge oscClk); rstReqN = 1;
    repeat (10) @(negedge oscClk);
    resetTag = "R5";
    // R6: one-stage ready
    readyTag = "R6"; oneStageSel = 1;
    driveReady(90, 0);
    // R7: two-stage ready
    readyTag = "R7"; oneStageSel = 0;
    driveReady(90, 0);
    // R8: depth select changing on the fly
    readyTag = "R8";
    driveReady(90, 1);
    // R1 then R2: re-sync in mid-run, phase must restart
    waitPhase(1); clkSync = 1;
    repeat (4) @(negedge oscClk);
    clkSync = 0; readyTag = "R6"; oneStageSel = 1;
    driveReady(40, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule